// File: doc/BRIEF.md
# Memory card SPI-mode bring-up sequencer

This block takes a memory card from power-up into SPI mode and leaves it ready for block transfers. It does not shift bits itself. It drives a lower-level command engine through a one-cycle request pulse, a request kind, a command index, a 32-bit argument and a check byte. The engine answers with a one-cycle completion pulse and the first response byte. The sequencer also drives a clock-select output. That output stays on the slow rate for the whole bring-up and moves to the fast rate only after a successful finish.

After a start request, the block first asks the engine for a run of idle bytes with chip select released. It then puts the card into its idle state. It probes the interface condition to decide between the older and newer card generations. It polls the application-specific initialise command until the card leaves the idle state, and gives up after a fixed number of attempts. On the newer path it reads the operating-condition register and discards the value. It then fixes the block length. The result is a 2-bit card class, an error flag and a one-cycle completion pulse.

Top module: `sd_init_seq`

## Requirements
- R1: After an accepted start, the first request has kind 0 (wake: idle bytes with chip select high) and argument 16, the byte count. The clock-select output is 0 (slow) at that time.
- R2: The next request is index 0 with argument 0 and check byte 0x95, kind 1 (R1 reply only). A reply of exactly 0x01 continues the sequence. Any other reply ends it as a failure.
- R3: The next request is index 8 with argument 0x000001AA and check byte 0x87, kind 1. A reply of 0x01 selects the newer-card path, 0x05 selects the older-card path, and any other reply is a failure.
- R4: On both paths the block issues index 55 (argument 0, reply not examined) and then index 41 (argument 0), both kind 1. It repeats this pair until index 41 replies 0x00.
- R5: At most 5000 index-41 requests are made. A non-zero reply to the 5000th is a failure, and a 0x00 reply to the 5000th still succeeds.
- R6: On the newer path only, a request with index 58 and kind 2 (R1 reply plus 4 trailing bytes) follows the successful index 41. Its reply is not examined. The older path skips it.
- R7: The last request is index 16 with argument 512, kind 1. A 0x00 reply is success and sets the clock-select output to 1 (fast). Any other reply is a failure and leaves the output at 0.
- R8: The card-class output reads 0 while busy and after a failure, 1 after an older-card success and 2 after a newer-card success. The error flag is 1 only after a failure. Both hold until the next accepted start, which also clears them and reselects the slow clock.
- R9: Busy rises in the cycle after an accepted start. It falls in the cycle where the completion pulse is high for exactly one cycle. Each request is a one-cycle pulse raised only while busy, in the cycle after the previous completion.
- R10: A start request while busy is ignored, and the command sequence is unchanged.
- R11: A synchronous reset returns the block to idle with no request pending, the slow clock selected, and class and error cleared. Completion pulses that arrive while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin bring-up (sampled while idle) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last sequence failed |
| card_type_o | output | 2 | 0 fail/none, 1 older card, 2 newer card |
| fast_clk_o | output | 1 | Clock select: 0 slow, 1 fast |
| cmd_start_o | output | 1 | One-cycle request to the command engine |
| cmd_kind_o | output | 2 | 0 wake bytes, 1 R1 reply, 2 R1 plus 4-byte trailer |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument (byte count for wake) |
| cmd_crc_o | output | 8 | Check byte to send |
| cmd_done_i | input | 1 | Engine completion pulse |
| cmd_resp_i | input | 8 | First response byte from the card |

## Verification
The hardest situation to reach is the attempt limit on the initialise poll. The card must reject index 41 exactly 4999 or 5000 times in a row, and the outcome turns on that single count. The bench's engine model answers every index-41 request from a per-scenario reject count. It runs both counts back to back with a one-cycle engine latency, so that about 10,000 polls fit in the run. A start pulse injected mid-sequence and a reset applied while a completion is still pending cover the two ways the flow can be disturbed from outside.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

  typedef enum logic [2:0] {
    STEP_WAKE,
    STEP_RESET,
    STEP_IFCOND,
    STEP_APP,
    STEP_OPCOND,
    STEP_OCR,
    STEP_BLKLEN
  } step_e;

  localparam logic [1:0] KIND_WAKE  = 2'd0;
  localparam logic [1:0] KIND_R1    = 2'd1;
  localparam logic [1:0] KIND_TRAIL = 2'd2;

  localparam logic [1:0] CARD_NONE = 2'd0;
  localparam logic [1:0] CARD_V1   = 2'd1;
  localparam logic [1:0] CARD_V2   = 2'd2;

  localparam logic [7:0] REPLY_IDLE     = 8'h01;
  localparam logic [7:0] REPLY_IDLE_ILL = 8'h05;
  localparam logic [7:0] REPLY_READY    = 8'h00;

endpackage

// File: rtl/sd_cmd_table.sv
module sd_cmd_table
  import sd_init_pkg::*;
#(
  parameter int WAKE_BYTES = 16,
  parameter int BLOCK_LEN  = 512
) (
  input  step_e       step_i,
  output logic [1:0]  kind_o,
  output logic [5:0]  idx_o,
  output logic [31:0] arg_o,
  output logic [7:0]  crc_o
);

  always_comb begin
    kind_o = KIND_R1;
    idx_o  = 6'd0;
    arg_o  = 32'd0;
    crc_o  = 8'h95;
    unique case (step_i)
      STEP_WAKE: begin
        kind_o = KIND_WAKE;
        arg_o  = 32'(WAKE_BYTES);
        crc_o  = 8'hFF;
      end
      STEP_RESET:  idx_o = 6'd0;
      STEP_IFCOND: begin
        idx_o = 6'd8;
        arg_o = 32'h0000_01AA;
        crc_o = 8'h87;
      end
      STEP_APP:    idx_o = 6'd55;
      STEP_OPCOND: idx_o = 6'd41;
      STEP_OCR: begin
        idx_o  = 6'd58;
        kind_o = KIND_TRAIL;
      end
      STEP_BLKLEN: begin
        idx_o = 6'd16;
        arg_o = 32'(BLOCK_LEN);
      end
      default: idx_o = 6'd0;
    endcase
  end

endmodule

// File: rtl/sd_retry_ctr.sv
module sd_retry_ctr #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic bump_i,
  output logic last_o
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (bump_i)  cnt_q <= cnt_q + 1'b1;
  end

  // attempt currently being answered is the final allowed one
  assign last_o = (cnt_q == CW'(LIMIT - 1));

  a_r5_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(LIMIT));

  a_r5_no_bump_past_last: assert property (@(posedge clk) disable iff (rst)
    (last_o && !clr_i) |-> !bump_i);

endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
  import sd_init_pkg::*;
#(
  parameter int WAKE_BYTES = 16,
  parameter int MAX_TRIES  = 5000,
  parameter int BLOCK_LEN  = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [1:0]  card_type_o,
  output logic        fast_clk_o,
  output logic        cmd_start_o,
  output logic [1:0]  cmd_kind_o,
  output logic [5:0]  cmd_idx_o,
  output logic [31:0] cmd_arg_o,
  output logic [7:0]  cmd_crc_o,
  input  logic        cmd_done_i,
  input  logic [7:0]  cmd_resp_i
);

  step_e      step_q, step_d;
  logic       busy_q, done_q, err_q, fast_q, v2_q, req_q;
  logic [1:0] type_q;
  logic       accept, evt, go, fin_ok, fin_bad, set_v2, bump, last_try;

  assign accept = !busy_q && start_i;
  assign evt    = busy_q && cmd_done_i;

  // next step decision on each engine completion
  always_comb begin
    step_d  = step_q;
    go      = 1'b0;
    fin_ok  = 1'b0;
    fin_bad = 1'b0;
    set_v2  = 1'b0;
    bump    = 1'b0;
    if (evt) begin
      unique case (step_q)
        STEP_WAKE: begin
          go = 1'b1; step_d = STEP_RESET;
        end
        STEP_RESET: begin
          if (cmd_resp_i == REPLY_IDLE) begin go = 1'b1; step_d = STEP_IFCOND; end
          else fin_bad = 1'b1;
        end
        STEP_IFCOND: begin
          if (cmd_resp_i == REPLY_IDLE) begin
            go = 1'b1; set_v2 = 1'b1; step_d = STEP_APP;
          end else if (cmd_resp_i == REPLY_IDLE_ILL) begin
            go = 1'b1; step_d = STEP_APP;
          end else fin_bad = 1'b1;
        end
        STEP_APP: begin
          go = 1'b1; step_d = STEP_OPCOND;
        end
        STEP_OPCOND: begin
          if (cmd_resp_i == REPLY_READY) begin
            go = 1'b1; step_d = v2_q ? STEP_OCR : STEP_BLKLEN;
          end else if (last_try) fin_bad = 1'b1;
          else begin
            go = 1'b1; bump = 1'b1; step_d = STEP_APP;
          end
        end
        STEP_OCR: begin
          go = 1'b1; step_d = STEP_BLKLEN;
        end
        STEP_BLKLEN: begin
          if (cmd_resp_i == REPLY_READY) fin_ok = 1'b1;
          else fin_bad = 1'b1;
        end
        default: fin_bad = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= STEP_WAKE;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      fast_q <= 1'b0;
      v2_q   <= 1'b0;
      req_q  <= 1'b0;
      type_q <= CARD_NONE;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= STEP_WAKE;
        req_q  <= 1'b1;
        err_q  <= 1'b0;
        fast_q <= 1'b0;
        v2_q   <= 1'b0;
        type_q <= CARD_NONE;
      end else if (go) begin
        step_q <= step_d;
        req_q  <= 1'b1;
        if (set_v2) v2_q <= 1'b1;
      end else if (fin_ok) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        fast_q <= 1'b1;
        type_q <= v2_q ? CARD_V2 : CARD_V1;
      end else if (fin_bad) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= 1'b1;
        type_q <= CARD_NONE;
      end
    end
  end

  sd_retry_ctr #(.LIMIT(MAX_TRIES)) u_retry (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (accept),
    .bump_i (bump),
    .last_o (last_try)
  );

  sd_cmd_table #(.WAKE_BYTES(WAKE_BYTES), .BLOCK_LEN(BLOCK_LEN)) u_table (
    .step_i (step_q),
    .kind_o (cmd_kind_o),
    .idx_o  (cmd_idx_o),
    .arg_o  (cmd_arg_o),
    .crc_o  (cmd_crc_o)
  );

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign card_type_o = type_q;
  assign fast_clk_o  = fast_q;
  assign cmd_start_o = req_q;

  a_r9_req_only_busy: assert property (@(posedge clk) disable iff (rst)
    cmd_start_o |-> busy_o);

  a_r9_req_single: assert property (@(posedge clk) disable iff (rst)
    cmd_start_o |=> !cmd_start_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  a_r7_fast_on_success: assert property (@(posedge clk) disable iff (rst)
    $rose(fast_clk_o) |-> (done_o && !err_o && card_type_o != CARD_NONE));

  a_r8_fail_outputs: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (card_type_o == CARD_NONE && !fast_clk_o));

  a_r1_slow_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !fast_clk_o);

endmodule

// File: tb/sd_init_seq_tb.sv
module sd_init_seq_tb;

  localparam int TRIES = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        busy_o, done_o, err_o, fast_clk_o, cmd_start_o;
  logic [1:0]  card_type_o, cmd_kind_o;
  logic [5:0]  cmd_idx_o;
  logic [31:0] cmd_arg_o;
  logic [7:0]  cmd_crc_o;
  logic        cmd_done_i = 1'b0;
  logic [7:0]  cmd_resp_i = 8'hFF;

  always #2.5 clk = ~clk;

  sd_init_seq u_dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .card_type_o(card_type_o), .fast_clk_o(fast_clk_o),
    .cmd_start_o(cmd_start_o), .cmd_kind_o(cmd_kind_o), .cmd_idx_o(cmd_idx_o),
    .cmd_arg_o(cmd_arg_o), .cmd_crc_o(cmd_crc_o),
    .cmd_done_i(cmd_done_i), .cmd_resp_i(cmd_resp_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
    end
  endtask

  function automatic string tag_of(input int c);
    case (c)
      100: return "R1";
      0:   return "R2";
      8:   return "R3";
      58:  return "R6";
      16:  return "R7";
      default: return "R4";
    endcase
  endfunction

  // scenario knobs for the engine model
  logic [7:0] sc_r0, sc_r8, sc_r16;
  int sc_fails = 0;
  int lat = 1;
  int a41 = 0;
  int ncmd = 0;

  // behavioural reference: expected outputs, updated each rising edge
  bit e_busy = 0, e_done = 0, e_err = 0, e_fast = 0, e_start = 0, m_v2 = 0;
  int e_type = 0, e_cmd = 100, m_tries = 0;
  bit cmp_en = 0;

  always @(posedge clk) begin
    if (rst) begin
      e_busy = 0; e_done = 0; e_err = 0; e_fast = 0; e_start = 0; e_type = 0;
    end else begin
      e_start = 0; e_done = 0;
      if (!e_busy) begin
        if (start_i) begin
          e_busy = 1; e_cmd = 100; e_start = 1; e_err = 0; e_type = 0;
          e_fast = 0; m_v2 = 0; m_tries = 0;
        end
      end else if (cmd_done_i) begin
        int nxt;
        bit bad, good;
        nxt = -1; bad = 0; good = 0;
        case (e_cmd)
          100: nxt = 0;
          0:   if (cmd_resp_i == 8'h01) nxt = 8; else bad = 1;
          8: begin
            if (cmd_resp_i == 8'h01) begin m_v2 = 1; nxt = 55; end
            else if (cmd_resp_i == 8'h05) nxt = 55;
            else bad = 1;
          end
          55:  nxt = 41;
          41: begin
            m_tries++;
            if (cmd_resp_i == 8'h00) nxt = m_v2 ? 58 : 16;
            else if (m_tries >= TRIES) bad = 1;
            else nxt = 55;
          end
          58:  nxt = 16;
          default: if (cmd_resp_i == 8'h00) good = 1; else bad = 1;
        endcase
        if (nxt >= 0) begin e_cmd = nxt; e_start = 1; end
        if (good) begin e_busy = 0; e_done = 1; e_fast = 1; e_type = m_v2 ? 2 : 1; end
        if (bad)  begin e_busy = 0; e_done = 1; e_err = 1; e_type = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(busy_o == e_busy, "R9 busy", busy_o, e_busy);
      chk(done_o == e_done, "R9 done", done_o, e_done);
      chk(cmd_start_o == e_start, "R9 request", cmd_start_o, e_start);
      chk(fast_clk_o == e_fast, "R7 clock select", fast_clk_o, e_fast);
      chk(err_o == e_err, "R8 error flag", err_o, e_err);
      chk(card_type_o == 2'(e_type), "R8 card class", card_type_o, e_type);
      if (e_start && cmd_start_o)
        chk(((cmd_kind_o == 2'd0) ? 100 : int'(cmd_idx_o)) == e_cmd, tag_of(e_cmd),
            (cmd_kind_o == 2'd0) ? 100 : cmd_idx_o, e_cmd);
    end
  end

  // command engine model: fields checked per request, reply after lat cycles
  initial begin
    forever begin
      @(negedge clk);
      cmd_done_i = 1'b0;
      cmd_resp_i = 8'hFF;
      if (cmd_start_o) begin
        ncmd++;
        if (cmd_kind_o == 2'd0) begin
          chk(cmd_arg_o == 32'd16, "R1 wake byte count", cmd_arg_o, 16);
          chk(fast_clk_o == 1'b0, "R1 slow clock at wake", fast_clk_o, 0);
        end else begin
          case (cmd_idx_o)
            6'd0: begin
              chk(cmd_arg_o == 32'd0 && cmd_crc_o == 8'h95 && cmd_kind_o == 2'd1,
                  "R2 reset fields", {cmd_kind_o, cmd_arg_o, cmd_crc_o}, {2'd1, 32'd0, 8'h95});
            end
            6'd8: begin
              chk(cmd_arg_o == 32'h1AA && cmd_crc_o == 8'h87 && cmd_kind_o == 2'd1,
                  "R3 probe fields", {cmd_kind_o, cmd_arg_o, cmd_crc_o}, {2'd1, 32'h1AA, 8'h87});
            end
            6'd55, 6'd41: begin
              chk(cmd_arg_o == 32'd0 && cmd_kind_o == 2'd1, "R4 poll fields",
                  {cmd_kind_o, cmd_arg_o}, {2'd1, 32'd0});
            end
            6'd58: chk(cmd_kind_o == 2'd2, "R6 trailer kind", cmd_kind_o, 2);
            6'd16: begin
              chk(cmd_arg_o == 32'd512 && cmd_kind_o == 2'd1, "R7 length fields",
                  {cmd_kind_o, cmd_arg_o}, {2'd1, 32'd512});
            end
            default: chk(1'b0, "R4 unexpected index", cmd_idx_o, 0);
          endcase
        end
        repeat (lat) @(negedge clk);
        if (cmd_kind_o == 2'd0 && ncmd == 1) cmd_resp_i = 8'hFF;
        case (cmd_idx_o)
          6'd0:  cmd_resp_i = sc_r0;
          6'd8:  cmd_resp_i = sc_r8;
          6'd55: cmd_resp_i = 8'h01;
          6'd41: begin
            cmd_resp_i = (a41 < sc_fails) ? 8'h01 : 8'h00;
            a41++;
          end
          6'd58: cmd_resp_i = 8'hC0;
          6'd16: cmd_resp_i = sc_r16;
          default: cmd_resp_i = 8'hFF;
        endcase
        if (cmd_kind_o == 2'd0) cmd_resp_i = 8'hFF;
        cmd_done_i = 1'b1;
      end
    end
  end

  task automatic run(input logic [7:0] r0, input logic [7:0] r8, input int nf,
                     input logic [7:0] r16, input int l, input bit poke);
    sc_r0 = r0; sc_r8 = r8; sc_fails = nf; sc_r16 = r16; lat = l;
    a41 = 0; ncmd = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic outcome(input string tag, input int ty, input bit er, input bit fa);
    chk(card_type_o == 2'(ty), tag, card_type_o, ty);
    chk(err_o == er, tag, err_o, er);
    chk(fast_clk_o == fa, tag, fast_clk_o, fa);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;
    // R11 reset state
    chk(busy_o == 0 && fast_clk_o == 0 && cmd_start_o == 0 && card_type_o == 0 && err_o == 0,
        "R11 reset state", {busy_o, fast_clk_o, cmd_start_o, card_type_o, err_o}, 0);

    // newer card, three rejected polls, stray start mid-way (R10)
    run(8'h01, 8'h01, 3, 8'h00, 2, 1'b1);
    outcome("R3 newer card success", 2, 0, 1);
    chk(ncmd == 13, "R10 stray start left sequence unchanged", ncmd, 13);

    // older card, no CMD58 (R6), immediate ready
    run(8'h01, 8'h05, 0, 8'h00, 1, 1'b0);
    outcome("R6 older card success", 1, 0, 1);
    chk(ncmd == 6, "R6 older path skips trailer request", ncmd, 6);

    // reset after success drops the fast clock (R11)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(fast_clk_o == 0 && card_type_o == 0, "R11 reset after success",
        {fast_clk_o, card_type_o}, 0);

    // bad idle reply (R2)
    run(8'h00, 8'h01, 0, 8'h00, 3, 1'b0);
    outcome("R2 bad reset reply", 0, 1, 0);
    chk(ncmd == 2, "R2 stops after reset command", ncmd, 2);

    // bad probe reply (R3)
    run(8'h01, 8'h09, 0, 8'h00, 1, 1'b0);
    outcome("R3 bad probe reply", 0, 1, 0);

    // block length rejected (R7)
    run(8'h01, 8'h01, 1, 8'h04, 1, 1'b0);
    outcome("R7 length rejected", 0, 1, 0);

    // restart after failure clears the flags (R8)
    sc_r0 = 8'h01; sc_r8 = 8'h05; sc_fails = 50; sc_r16 = 8'h00; a41 = 0; ncmd = 0; lat = 1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(err_o == 0 && busy_o == 1, "R8 start clears error", {err_o, busy_o}, 1);

    // reset mid-sequence with a completion still pending (R11)
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(busy_o == 0 && cmd_start_o == 0 && fast_clk_o == 0, "R11 reset mid-sequence",
        {busy_o, cmd_start_o, fast_clk_o}, 0);
    repeat (10) @(negedge clk);
    chk(busy_o == 0, "R11 pending completion ignored while idle", busy_o, 0);

    // attempt limit boundary: 4999 rejects succeed, 5000 rejects fail (R5)
    run(8'h01, 8'h05, TRIES - 1, 8'h00, 1, 1'b0);
    outcome("R5 success on final attempt", 1, 0, 1);
    chk(a41 == TRIES, "R5 poll count at success", a41, TRIES);
    run(8'h01, 8'h01, TRIES, 8'h00, 1, 1'b0);
    outcome("R5 attempt limit reached", 0, 1, 0);
    chk(a41 == TRIES, "R5 poll count at limit", a41, TRIES);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule